// File: doc/BRIEF.md
# Serial Transmitter with Break Generation and Handshake-Cleared Status

This block is the transmit half of an asynchronous serial port. Software places a character in a holding register and the block moves it into a shift register when the line is free. It then sends a low start bit, the data bits least-significant first, and a high stop bit, one bit per baud tick. Characters carry 8 data bits, or 9 when the wide-character option is set. A separate request line makes the block send break characters: runs of zero bits longer than any legal character. A long-break option adds three more zero bits to each break.

Two status flags report progress. The empty flag means the holding register may take a new character. The complete flag means nothing is being shifted out and the line is idle. Software clears the empty flag in two steps. First it reads the status register while the flag is set. Then it writes the low data register. Other accesses may come between the two steps. The complete flag clears by itself whenever work is queued. The six low status bits belong to receive functions that are not part of this block, and they always read zero.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `status` reads 8'hC0 (empty flag in bit 7 and complete flag in bit 6 both 1) and `txd` is 1.
- R2: Bits 5 to 0 of `status` always read 0.
- R3: When a character is loaded, `txd` shows the start bit 0, then each data bit LSB first, then the stop bit 1. Data bits are bits 7 to 0 of the low data register, and in 9-bit mode bit 8 is the value last written through `data_wr_hi` (`wdata[0]`). Each bit lasts from one `baud_tick` to the next, and `txd` never changes on a cycle without a tick.
- R4: The empty flag (bit 7) rises on the tick at which the shift register takes the character from the holding register.
- R5: The empty flag clears only on a `data_wr_lo` cycle that comes after a `stat_rd` cycle which saw the flag at 1. Other accesses in between are allowed. A `data_wr_lo` with no such earlier read leaves the flag set, and no character is sent.
- R6: The complete flag (bit 6) is 0 while a character or break is loaded or being sent, including back-to-back characters. It rises on the tick that ends the last activity, provided the empty flag is set. While it is 1, `txd` is 1.
- R7: The complete flag clears on its own one cycle after the empty flag is cleared by the handshake, or one cycle after any cycle with `send_brk` high.
- R8: When the complete flag is set and cleared on the same cycle, it ends at 0. An example is a handshake write that lands on the tick ending the last stop bit.
- R9: A break holds `txd` at 0 for 10 ticks in 8-bit mode or 11 in 9-bit mode. With `cfg_long_brk` set it lasts 13 or 14 ticks.
- R10: A break, once started, runs to its full length. It is followed by exactly one idle bit (1) before anything else. If `send_brk` drops during the first break, exactly one break is sent. If `send_brk` is held, breaks repeat with that single idle bit between them.
- R11: A `stat_rd` that sees the empty flag at 0 does not arm the clear. A later `data_wr_lo` after the flag has risen leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit time |
| cfg_nine | input | 1 | 1 selects 9 data bits per character |
| cfg_long_brk | input | 1 | 1 lengthens each break by three zero bits |
| send_brk | input | 1 | Break request, level-sensitive |
| stat_rd | input | 1 | Status register read strobe |
| data_wr_hi | input | 1 | Write strobe for data bit 8, taken from wdata[0] |
| data_wr_lo | input | 1 | Write strobe for the low data byte |
| wdata | input | DATA_W | Write data |
| status | output | 8 | {empty, complete, 6'b0} |
| txd | output | 1 | Serial output line, idle high |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse, and that `cfg_nine` and `cfg_long_brk` change only while the line is idle. The bench changes the configuration only after the complete flag has risen, and it drives each tick high for exactly one clock. Bus strobes are pulsed one cycle at a time, and they meet a tick on the same cycle only where the same-cycle set/clear case is under test. The bench measures break lengths and the idle gap by counting ticks on `txd`. It does not assume how the engine counts internally.

// File: rtl/uart_tx_brk_pkg.sv
package uart_tx_brk_pkg;

    // Shift engine activity
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_BREAK = 2'd2,
        ST_GAP   = 2'd3
    } tx_state_e;

    localparam int unsigned STATUS_W = 8;

endpackage

// File: rtl/uart_tx_hold.sv
// Holding register plus the empty / complete flags and the read-then-write
// clear handshake.
module uart_tx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              data_wr_hi,
    input  logic              data_wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,       // shifter took the character
    input  logic              done_idle,  // shifter fell idle
    input  logic              brk_req,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_x,
    output logic              tdre,
    output logic              tc
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              x;
        logic              tdre;
        logic              tc;
        logic              arm;
    } hold_t;

    hold_t q, d;
    logic  clr_tdre;
    logic  tc_clr;

    always_comb begin
        d = q;

        if (data_wr_lo) d.data = wdata;
        if (data_wr_hi) d.x    = wdata[0];

        // second step of the handshake
        clr_tdre = data_wr_lo && q.arm && q.tdre;

        if (take)          d.tdre = 1'b1;
        else if (clr_tdre) d.tdre = 1'b0;

        // arm on a read that saw the flag set; drop when used or when the
        // flag is no longer set
        if (clr_tdre)                d.arm = 1'b0;
        else if (stat_rd && q.tdre)  d.arm = 1'b1;
        else if (!q.tdre)            d.arm = 1'b0;

        // complete flag: a clear beats a set on the same cycle
        tc_clr = clr_tdre || brk_req || take;
        if (tc_clr)         d.tc = 1'b0;
        else if (done_idle) d.tc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.data <= '0;
            q.x    <= 1'b0;
            q.tdre <= 1'b1;
            q.tc   <= 1'b1;
            q.arm  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hold_data = q.data;
    assign hold_x    = q.x;
    assign tdre      = q.tdre;
    assign tc        = q.tc;

endmodule

// File: rtl/uart_tx_shift.sv
// Bit engine: frames, breaks and the idle bit after a break.
module uart_tx_shift
    import uart_tx_brk_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned LONG_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cfg_nine,
    input  logic              cfg_long_brk,
    input  logic              brk_req,
    input  logic              data_rdy,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_x,
    output logic              take,
    output logic              done_idle,
    output logic              txd
);

    localparam int unsigned SH_W    = DATA_W + 3;
    localparam int unsigned MAX_LEN = DATA_W + 3 + LONG_EXTRA;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-1:0]   sh;
    } shf_t;

    shf_t q, d;

    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] brk_len;
    logic [SH_W-1:0]  frame_img;
    logic             pick;

    always_comb begin
        frame_len = CNT_W'(DATA_W + 2) + {{(CNT_W-1){1'b0}}, cfg_nine};
        brk_len   = frame_len + (cfg_long_brk ? CNT_W'(LONG_EXTRA) : '0);
        frame_img = cfg_nine ? {1'b1, hold_x, hold_data, 1'b0}
                             : {2'b11, hold_data, 1'b0};
    end

    always_comb begin
        d         = q;
        pick      = 1'b0;
        take      = 1'b0;
        done_idle = 1'b0;

        if (baud_tick) begin
            unique case (q.st)
                ST_FRAME: begin
                    if (q.cnt == CNT_W'(1)) begin
                        pick = 1'b1;
                    end else begin
                        d.sh  = {1'b1, q.sh[SH_W-1:1]};
                        d.cnt = q.cnt - CNT_W'(1);
                    end
                end
                ST_BREAK: begin
                    if (q.cnt == CNT_W'(1)) d.st  = ST_GAP;
                    else                    d.cnt = q.cnt - CNT_W'(1);
                end
                default: pick = 1'b1;  // ST_IDLE, ST_GAP
            endcase
        end

        if (pick) begin
            if (brk_req) begin
                d.st  = ST_BREAK;
                d.cnt = brk_len;
            end else if (data_rdy) begin
                d.st  = ST_FRAME;
                d.cnt = frame_len;
                d.sh  = frame_img;
                take  = 1'b1;
            end else begin
                d.st      = ST_IDLE;
                done_idle = (q.st != ST_IDLE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.cnt <= '0;
            q.sh  <= '1;
        end else begin
            q <= d;
        end
    end

    assign txd = (q.st == ST_FRAME) ? q.sh[0] : (q.st != ST_BREAK);

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import uart_tx_brk_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned LONG_EXTRA = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                cfg_nine,
    input  logic                cfg_long_brk,
    input  logic                send_brk,
    input  logic                stat_rd,
    input  logic                data_wr_hi,
    input  logic                data_wr_lo,
    input  logic [DATA_W-1:0]   wdata,
    output logic [STATUS_W-1:0] status,
    output logic                txd
);

    localparam int unsigned RSVD_W = STATUS_W - 2;

    logic [DATA_W-1:0] hold_data;
    logic              hold_x;
    logic              tdre;
    logic              tc;
    logic              take;
    logic              done_idle;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_rd    (stat_rd),
        .data_wr_hi (data_wr_hi),
        .data_wr_lo (data_wr_lo),
        .wdata      (wdata),
        .take       (take),
        .done_idle  (done_idle),
        .brk_req    (send_brk),
        .hold_data  (hold_data),
        .hold_x     (hold_x),
        .tdre       (tdre),
        .tc         (tc)
    );

    uart_tx_shift #(.DATA_W(DATA_W), .LONG_EXTRA(LONG_EXTRA)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .cfg_nine     (cfg_nine),
        .cfg_long_brk (cfg_long_brk),
        .brk_req      (send_brk),
        .data_rdy     (!tdre),
        .hold_data    (hold_data),
        .hold_x       (hold_x),
        .take         (take),
        .done_idle    (done_idle),
        .txd          (txd)
    );

    // receive-side positions are reserved
    assign status = {tdre, tc, {RSVD_W{1'b0}}};

endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       send_brk,
    input logic       data_wr_lo,
    input logic [7:0] status,
    input logic       txd
);

    AST_TXD_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd)); // R3

    AST_EMPTY_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[7]) |-> $past(baud_tick)); // R4

    AST_EMPTY_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |-> $past(data_wr_lo)); // R5

    AST_COMPLETE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> txd); // R6

    AST_COMPLETE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> status[7]); // R6

    AST_BREAK_DROPS_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        send_brk |=> !status[6]); // R7

endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .send_brk   (send_brk),
    .data_wr_lo (data_wr_lo),
    .status     (status),
    .txd        (txd)
);

// File: tb/sim_uart_tx_brk.sv
`timescale 1ns/1ps
module sim_uart_tx_brk;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       cfg_nine = 1'b0;
    logic       cfg_long_brk = 1'b0;
    logic       send_brk = 1'b0;
    logic       stat_rd = 1'b0;
    logic       data_wr_hi = 1'b0;
    logic       data_wr_lo = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] status;
    logic       txd;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_tx_brk u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_nine(cfg_nine),
        .cfg_long_brk(cfg_long_brk), .send_brk(send_brk), .stat_rd(stat_rd),
        .data_wr_hi(data_wr_hi), .data_wr_lo(data_wr_lo), .wdata(wdata),
        .status(status), .txd(txd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic rd();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic wlo(input logic [7:0] v);
        data_wr_lo = 1'b1; wdata = v;
        @(negedge clk);
        data_wr_lo = 1'b0;
    endtask

    task automatic whi(input logic b);
        data_wr_hi = 1'b1; wdata = {7'd0, b};
        @(negedge clk);
        data_wr_hi = 1'b0;
    endtask

    // load tick, data bits, stop bit; leaves the engine in the stop bit
    task automatic run_bits(input string req, input logic [7:0] v, input logic x);
        int nb;
        nb = cfg_nine ? 9 : 8;
        tick();
        chk({req, " R3 start"}, txd, 0);
        chk({req, " R4 empty on load"}, status[7], 1);
        chk({req, " R6 busy"}, status[6], 0);
        for (int i = 0; i < nb; i++) begin
            tick();
            chk({req, " R3 data bit"}, txd, (i < 8) ? v[i] : x);
        end
        tick();
        chk({req, " R3 stop"}, txd, 1);
        chk({req, " R6 busy in stop"}, status[6], 0);
    endtask

    task automatic send_frame(input logic [7:0] v, input logic x);
        rd();
        whi(x);
        wlo(v);
        chk("R5 handshake clears empty", status[7], 0);
        chk("R7 complete auto clear", status[6], 0);
        run_bits("frame", v, x);
        tick();
        chk("R6 complete after frame", status, 8'hC0);
        chk("R6 line idle", txd, 1);
    endtask

    function automatic int brk_exp();
        return 10 + (cfg_nine ? 1 : 0) + (cfg_long_brk ? 3 : 0);
    endfunction

    // count zero ticks of a break already showing on txd
    task automatic count_zeros(output int z);
        z = 1;
        for (int k = 0; k < 40 && txd == 1'b0; k++) begin
            tick();
            if (txd == 1'b0) z++;
        end
    endtask

    initial begin
        logic [7:0] pats [6];
        int z, g;
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

        repeat (3) @(negedge clk);
        chk("R1 reset status", status, 8'hC0);
        chk("R1 reset line", txd, 1);
        chk("R2 reserved zero", status[5:0], 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: both widths, both break lengths, data patterns, bit 8
        for (int m = 0; m < 4; m++) begin
            cfg_nine = m[0];
            cfg_long_brk = m[1];
            for (int p = 0; p < 6; p++)
                for (int xb = 0; xb < 2; xb++)
                    send_frame(pats[p] ^ 8'(p * 17 + m), xb[0]);
            chk("R2 reserved zero", status[5:0], 0);

            // single break: pulse, then drop while it runs
            send_brk = 1'b1;
            @(negedge clk);
            chk("R7 break clears complete", status[6], 0);
            tick();
            send_brk = 1'b0;
            chk("R10 break started", txd, 0);
            count_zeros(z);
            chk("R9 break length", z, brk_exp());
            chk("R10 idle bit after break", txd, 1);
            tick();
            chk("R10 single break back to idle", status, 8'hC0);
            repeat (3) begin
                tick();
                chk("R10 no second break", txd, 1);
            end

            // held break: two in a row with one idle bit between
            send_brk = 1'b1;
            tick();
            count_zeros(z);
            chk("R9 held break length", z, brk_exp());
            g = 1;
            for (int k = 0; k < 5; k++) begin
                tick();
                if (txd == 1'b1) g++;
                else break;
            end
            chk("R10 gap between breaks", g, 1);
            send_brk = 1'b0;
            count_zeros(z);
            chk("R10 second break full length", z, brk_exp());
            tick();
            chk("R6 complete after breaks", status, 8'hC0);
        end

        cfg_nine = 1'b0;
        cfg_long_brk = 1'b0;

        // write without read: ignored
        wlo(8'h11);
        chk("R5 write without read keeps empty", status, 8'hC0);
        tick();
        chk("R5 nothing sent", txd, 1);
        chk("R5 still idle", status, 8'hC0);

        // read that saw empty clear does not arm
        rd(); wlo(8'h3C);
        rd();
        run_bits("R11", 8'h3C, 1'b0);
        wlo(8'h77);
        chk("R11 unarmed write keeps empty", status[7], 1);
        tick();
        chk("R11 idle after", status, 8'hC0);
        tick();
        chk("R11 no frame from unarmed write", txd, 1);

        // other access between read and write
        rd(); whi(1'b1); wlo(8'h42);
        chk("R5 split handshake clears", status[7], 0);
        run_bits("R5 split", 8'h42, 1'b1);
        tick();
        chk("R5 split idle", status, 8'hC0);

        // back-to-back frames keep complete low
        rd(); wlo(8'hC3);
        tick();
        rd(); wlo(8'h2D);
        chk("R6 second queued", status, 8'h00);
        for (int i = 0; i < 9; i++) tick();
        tick();
        chk("R6 next start at once", txd, 0);
        chk("R6 complete stays low", status, 8'h80);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R3 second frame bit", txd, (8'h2D >> i) & 1);
        end
        tick(); tick();
        chk("R6 idle after pair", status, 8'hC0);

        // clear wins when it meets the set on the final tick
        rd(); wlo(8'h96);
        run_bits("R8", 8'h96, 1'b0);
        rd();
        baud_tick = 1'b1; data_wr_lo = 1'b1; wdata = 8'h69;
        @(negedge clk);
        baud_tick = 1'b0; data_wr_lo = 1'b0;
        chk("R8 clear beats set", status, 8'h00);
        chk("R8 line idle", txd, 1);
        run_bits("R8 follow", 8'h69, 1'b0);
        tick();
        chk("R8 final idle", status, 8'hC0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule